// File: doc/BRIEF.md
# Multi-Sector XTS Tweak Generator

This block supplies the tweak values for XTS-mode storage encryption over one request covering one to eight consecutive 512-byte sectors. A request carries a starting sector number and a byte length. The block first sends out one 128-bit initialization value per sector. Each value is the sector's number. The values go out as one back-to-back batch, so an external ECB cipher can encrypt all of them in a single pass. The block then takes the encrypted values back in the same order.

With every encrypted sector value stored, the block streams the tweaks. A sector holds 32 data units of 128 bits each. The tweak for unit j of a sector is that sector's encrypted value multiplied by alpha to the power j in GF(2^128). The exponent goes back to zero at every sector boundary. The cipher, the keys and the data XOR path sit outside the block.

Top module: `xts_tweak_gen`

## Requirements
- R1: After reset the block is idle. In that state reqReady is 1, and ivValid, encReady, twValid, done and reqErr are all 0.
- R2: A request is accepted only when its length is a nonzero multiple of 512 bytes and at most 4096 bytes. Any other length raises reqErr for exactly one cycle, in the cycle after the request. In that case no IV is emitted and reqReady stays 1.
- R3: A valid request of N sectors emits exactly N IVs on ivData, in order. IV i equals the start sector plus i, modulo 2^128. The value is stored little-endian, with byte k at bits [8k+7:8k], so the vector equals the integer.
- R4: encReady is 1 only after the last IV has been transferred. It stays 1 until exactly N encrypted IVs have been accepted. No tweak is offered before that point.
- R5: Tweak j of a sector equals that sector's encrypted IV times alpha^j. One multiply by alpha shifts the 128-bit vector left by one bit. When the bit shifted out of bit 127 is 1, 0x87 is XORed into bits [7:0].
- R6: Tweaks come out in sector order, and within each sector for units 0 to 31. That gives 32*N tweaks in total. The exponent restarts at 0 with the first unit of every sector.
- R7: While ivValid or twValid is 1 and the matching ready is 0, the data output holds steady. The tweak advances only on a completed transfer.
- R8: One cycle after the last tweak is accepted, done is 1 for exactly one cycle and reqReady is 1 again.
- R9: reqReady is 0 outside idle. A request offered while a previous one is in progress has no effect on the IVs or tweaks being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block is idle and will take a request |
| reqSector | input | 128 | First sector number |
| reqBytes | input | 13 | Request length in bytes |
| reqErr | output | 1 | One-cycle pulse: rejected length |
| ivValid | output | 1 | Sector IV available |
| ivReady | input | 1 | Cipher takes the IV |
| ivData | output | 128 | Sector IV, little-endian |
| encValid | input | 1 | Encrypted IV offered |
| encReady | output | 1 | Block takes an encrypted IV |
| encData | input | 128 | Encrypted IV |
| twValid | output | 1 | Tweak available |
| twReady | input | 1 | Consumer takes the tweak |
| twData | output | 128 | Tweak value |
| done | output | 1 | One-cycle pulse after the final tweak |

## Verification
The bench attacks the cases where the exponent must restart. A design that kept multiplying across a sector boundary would give a wrong unit-0 tweak for every sector after the first. It runs a start sector of all ones with eight sectors, which catches a carry lost when the IV wraps. It also uses encrypted values with bit 127 set, which catches a missing 0x87 reduction. It offers lengths such as 0, 100, 513, 4608 and 8191, where a lax length check would start a run instead of pulsing reqErr. It uses random ready stalls and requests offered while busy, to expose a tweak that advances without a transfer or a request that is taken mid-run.

// File: rtl/tweak_pkg.sv
package tweak_pkg;
  localparam int UNIT_BITS = 128;

  typedef enum logic [1:0] {ST_IDLE, ST_IVOUT, ST_ENCIN, ST_TWEAK} tweakState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic ivStep;
    logic encWrite;
    logic twStep;
  } dpCtrl_t;

  // multiply by alpha, little-endian vector, poly x^128+x^7+x^2+x+1
  function automatic logic [UNIT_BITS-1:0] mulAlpha(input logic [UNIT_BITS-1:0] v);
    return {v[UNIT_BITS-2:0], 1'b0} ^ (v[UNIT_BITS-1] ? 128'h87 : 128'h0);
  endfunction
endpackage

// File: rtl/tweak_dp.sv
module tweak_dp
  import tweak_pkg::*;
#(
  parameter int MAX_SECTORS  = 8,
  parameter int SECTOR_BYTES = 512,
  localparam int UNITS  = SECTOR_BYTES * 8 / UNIT_BITS,
  localparam int UNIT_W = $clog2(UNITS),
  localparam int IDX_W  = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1,
  localparam int CNT_W  = $clog2(MAX_SECTORS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              ctrl,
  input  logic [UNIT_BITS-1:0] reqSector,
  input  logic [CNT_W-1:0]     reqCount,
  input  logic [UNIT_BITS-1:0] encData,
  output logic [UNIT_BITS-1:0] ivData,
  output logic [UNIT_BITS-1:0] twData,
  output logic                 lastIv,
  output logic                 lastEnc,
  output logic                 lastUnit,
  output logic                 lastSec
);
  logic [UNIT_BITS-1:0] baseSector;
  logic [UNIT_BITS-1:0] tweakReg;
  logic [UNIT_BITS-1:0] encMem [MAX_SECTORS];
  logic [CNT_W-1:0]     count;
  logic [IDX_W-1:0]     ivIdx, encIdx, secIdx;
  logic [UNIT_W-1:0]    unitIdx;

  assign ivData   = baseSector + UNIT_BITS'(ivIdx);
  assign twData   = (unitIdx == '0) ? encMem[secIdx] : tweakReg;
  assign lastIv   = (CNT_W'(ivIdx)  == count - CNT_W'(1));
  assign lastEnc  = (CNT_W'(encIdx) == count - CNT_W'(1));
  assign lastSec  = (CNT_W'(secIdx) == count - CNT_W'(1));
  assign lastUnit = (unitIdx == UNIT_W'(UNITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseSector <= '0;
      tweakReg   <= '0;
      count      <= '0;
      ivIdx      <= '0;
      encIdx     <= '0;
      secIdx     <= '0;
      unitIdx    <= '0;
    end else begin
      if (ctrl.loadReq) begin
        baseSector <= reqSector;
        count      <= reqCount;
        ivIdx      <= '0;
        encIdx     <= '0;
        secIdx     <= '0;
        unitIdx    <= '0;
      end
      if (ctrl.ivStep)   ivIdx  <= ivIdx + IDX_W'(1);
      if (ctrl.encWrite) encIdx <= encIdx + IDX_W'(1);
      if (ctrl.twStep) begin
        tweakReg <= mulAlpha(twData);
        if (lastUnit) begin
          unitIdx <= '0;
          secIdx  <= secIdx + IDX_W'(1);
        end else begin
          unitIdx <= unitIdx + UNIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.encWrite) encMem[encIdx] <= encData;
  end

  // R5
  alpha_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.twStep && !lastUnit) |=> (twData == mulAlpha($past(twData))));

  // R6
  unit_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.twStep && lastUnit) |=> (unitIdx == '0));
endmodule

// File: rtl/tweak_ctrl.sv
module tweak_ctrl
  import tweak_pkg::*;
#(
  parameter int MAX_SECTORS  = 8,
  parameter int SECTOR_BYTES = 512,
  localparam int MAX_BYTES = MAX_SECTORS * SECTOR_BYTES,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int SEC_SH    = $clog2(SECTOR_BYTES),
  localparam int CNT_W     = $clog2(MAX_SECTORS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqBytes,
  input  logic             ivReady,
  input  logic             encValid,
  input  logic             twReady,
  input  logic             lastIv,
  input  logic             lastEnc,
  input  logic             lastUnit,
  input  logic             lastSec,
  output dpCtrl_t          ctrl,
  output logic [CNT_W-1:0] reqCount,
  output logic             reqReady,
  output logic             ivValid,
  output logic             encReady,
  output logic             twValid,
  output logic             reqErr,
  output logic             done
);
  tweakState_t state, stateNext;
  logic accept, lenOk;

  assign lenOk = (reqBytes[SEC_SH-1:0] == '0) && (reqBytes != '0) &&
                 (reqBytes <= LEN_W'(MAX_BYTES));
  assign reqCount = CNT_W'(reqBytes >> SEC_SH);

  assign reqReady = (state == ST_IDLE);
  assign ivValid  = (state == ST_IVOUT);
  assign encReady = (state == ST_ENCIN);
  assign twValid  = (state == ST_TWEAK);
  assign accept   = reqValid && reqReady;

  assign ctrl.loadReq  = accept && lenOk;
  assign ctrl.ivStep   = ivValid && ivReady;
  assign ctrl.encWrite = encValid && encReady;
  assign ctrl.twStep   = twValid && twReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (ctrl.loadReq) stateNext = ST_IVOUT;
      ST_IVOUT: if (ctrl.ivStep && lastIv) stateNext = ST_ENCIN;
      ST_ENCIN: if (ctrl.encWrite && lastEnc) stateNext = ST_TWEAK;
      ST_TWEAK: if (ctrl.twStep && lastUnit && lastSec) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      reqErr <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= stateNext;
      reqErr <= accept && !lenOk;
      done   <= ctrl.twStep && lastUnit && lastSec;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (reqReady && !ivValid));
endmodule

// File: rtl/xts_tweak_gen.sv
module xts_tweak_gen
  import tweak_pkg::*;
#(
  parameter int MAX_SECTORS  = 8,
  parameter int SECTOR_BYTES = 512,
  localparam int LEN_W = $clog2(MAX_SECTORS * SECTOR_BYTES + 1),
  localparam int CNT_W = $clog2(MAX_SECTORS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [127:0]     reqSector,
  input  logic [LEN_W-1:0] reqBytes,
  output logic             reqErr,
  output logic             ivValid,
  input  logic             ivReady,
  output logic [127:0]     ivData,
  input  logic             encValid,
  output logic             encReady,
  input  logic [127:0]     encData,
  output logic             twValid,
  input  logic             twReady,
  output logic [127:0]     twData,
  output logic             done
);
  dpCtrl_t          ctrl;
  logic [CNT_W-1:0] reqCount;
  logic             lastIv, lastEnc, lastUnit, lastSec;

  tweak_ctrl #(.MAX_SECTORS(MAX_SECTORS), .SECTOR_BYTES(SECTOR_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBytes(reqBytes),
    .ivReady(ivReady), .encValid(encValid), .twReady(twReady),
    .lastIv(lastIv), .lastEnc(lastEnc), .lastUnit(lastUnit), .lastSec(lastSec),
    .ctrl(ctrl), .reqCount(reqCount), .reqReady(reqReady), .ivValid(ivValid),
    .encReady(encReady), .twValid(twValid), .reqErr(reqErr), .done(done)
  );

  tweak_dp #(.MAX_SECTORS(MAX_SECTORS), .SECTOR_BYTES(SECTOR_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqSector(reqSector),
    .reqCount(reqCount), .encData(encData), .ivData(ivData), .twData(twData),
    .lastIv(lastIv), .lastEnc(lastEnc), .lastUnit(lastUnit), .lastSec(lastSec)
  );

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, ivValid, encReady, twValid}));

  // R7
  iv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ivValid && !ivReady) |=> (ivValid && $stable(ivData)));

  // R7
  tw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (twValid && !twReady) |=> (twValid && $stable(twData)));
endmodule

// File: tb/xts_tweak_gen_tb.sv
module xts_tweak_gen_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [127:0] reqSector = '0;
  logic [12:0]  reqBytes = '0;
  logic         reqErr;
  logic         ivValid;
  logic         ivReady = 1'b0;
  logic [127:0] ivData;
  logic         encValid = 1'b0;
  logic         encReady;
  logic [127:0] encData = '0;
  logic         twValid;
  logic         twReady = 1'b0;
  logic [127:0] twData;
  logic         done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xts_tweak_gen dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSector(reqSector), .reqBytes(reqBytes), .reqErr(reqErr),
    .ivValid(ivValid), .ivReady(ivReady), .ivData(ivData),
    .encValid(encValid), .encReady(encReady), .encData(encData),
    .twValid(twValid), .twReady(twReady), .twData(twData), .done(done)
  );

  function automatic logic [127:0] refAlpha(input logic [127:0] v);
    logic [127:0] r;
    r = v << 1;
    if (v[127]) r[7:0] = r[7:0] ^ 8'h87;
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic badReq(input logic [12:0] bytes);
    @(negedge clk);
    reqValid = 1'b1; reqBytes = bytes; reqSector = rnd128();
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk(reqErr == 1'b1, "R2 err pulse", 128'(reqErr), 128'd1);
    chk(!ivValid && reqReady, "R2 no start", 128'({ivValid, reqReady}), 128'b01);
    @(negedge clk); #1;
    chk(reqErr == 1'b0, "R2 err one cycle", 128'(reqErr), 128'd0);
    chk(!ivValid, "R2 still idle", 128'(ivValid), 128'd0);
  endtask

  task automatic goodReq(input logic [127:0] start, input int nSec,
                         input int stallPct, input bit poke, input bit topBits);
    logic [127:0] encVals [8];
    logic [127:0] exp, held;
    bit heldOk;
    int got;
    for (int i = 0; i < nSec; i++) begin
      encVals[i] = rnd128();
      if (topBits) encVals[i][127] = 1'b1;
    end
    @(negedge clk);
    reqValid = 1'b1; reqSector = start; reqBytes = 13'(nSec * 512);
    @(negedge clk);
    reqValid = poke; reqSector = ~start; reqBytes = 13'd1024;
    // IV phase
    got = 0; heldOk = 1'b0; held = '0;
    while (got < nSec) begin
      ivReady = ($urandom % 100) >= stallPct;
      #1;
      chk(ivValid, "R3 iv valid", 128'(ivValid), 128'd1);
      chk(!encReady && !twValid, "R4 no early enc", 128'({encReady, twValid}), 128'd0);
      if (poke) chk(!reqReady, "R9 busy", 128'(reqReady), 128'd0);
      if (heldOk) chk(ivData == held, "R7 iv hold", ivData, held);
      if (ivReady) begin
        chk(ivData == start + 128'(got), "R3 iv value", ivData, start + 128'(got));
        got++; heldOk = 1'b0;
      end else begin
        held = ivData; heldOk = 1'b1;
      end
      @(negedge clk);
    end
    ivReady = 1'b0;
    // encrypted IV phase
    got = 0;
    while (got < nSec) begin
      encValid = ($urandom % 100) >= stallPct;
      encData = encVals[got];
      #1;
      chk(encReady && !twValid, "R4 enc accept", 128'({encReady, twValid}), 128'b10);
      if (encValid) got++;
      @(negedge clk);
    end
    encValid = 1'b0;
    // tweak phase
    for (int s = 0; s < nSec; s++) begin
      exp = encVals[s];
      for (int j = 0; j < 32; j++) begin
        heldOk = 1'b0;
        do begin
          twReady = ($urandom % 100) >= stallPct;
          #1;
          chk(twValid, "R6 tweak valid", 128'(twValid), 128'd1);
          if (heldOk) chk(twData == held, "R7 tweak hold", twData, held);
          if (twReady) chk(twData == exp, (j == 0) ? "R6 restart" : "R5 tweak", twData, exp);
          else begin held = twData; heldOk = 1'b1; end
          @(negedge clk);
        end while (!twReady);
        exp = refAlpha(exp);
      end
    end
    twReady = 1'b0; reqValid = 1'b0;
    #1;
    chk(done && reqReady && !twValid, "R8 done", 128'({done, reqReady, twValid}), 128'b110);
    @(negedge clk); #1;
    chk(!done, "R8 done one cycle", 128'(done), 128'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 128'd0, 128'd1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(reqReady && !ivValid && !encReady && !twValid && !done && !reqErr,
        "R1 reset idle", 128'({reqReady, ivValid, encReady, twValid, done, reqErr}),
        128'b100000);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(reqReady && !ivValid, "R1 after release", 128'({reqReady, ivValid}), 128'b10);
    // R2 rejected lengths
    badReq(13'd0);
    badReq(13'd100);
    badReq(13'd513);
    badReq(13'd4608);
    badReq(13'd8191);
    // directed: single sector, no stalls
    goodReq(128'd5, 1, 0, 1'b0, 1'b0);
    // R3 wrap across 2^128
    goodReq({128{1'b1}}, 8, 30, 1'b1, 1'b1);
    // R5 reduction heavy
    goodReq(128'h1234, 2, 0, 1'b0, 1'b1);
    // R9 busy pokes with stalls
    goodReq(rnd128(), 3, 50, 1'b1, 1'b0);
    // random mix
    for (int k = 0; k < 8; k++)
      goodReq(rnd128(), 1 + ($urandom % 8), $urandom % 60, 1'($urandom % 2), 1'($urandom % 2));
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule